// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects a synchronous request port to an external asynchronous static RAM holding 512K bytes. A client offers one access at a time with a valid/ready handshake: a write flag, a 19-bit word address and a byte of write data. The controller then drives the RAM's active-low select, output-enable and write-enable strobes and its address lines. For a read it returns the fetched byte with a single-cycle valid strobe.

The RAM's data pins are bidirectional. The controller does not instantiate a pad buffer. It presents an outgoing byte, a driver-enable and an incoming byte, and the pad logic above it joins them into one tri-stated bus. Every analogue timing minimum of the RAM is a nanosecond parameter. Each one is turned into a whole number of clock cycles by rounding up against the clock period, with at least one cycle per phase. Between accesses the RAM is left deselected, which is its standby state.

The cycle counts in the requirements below hold for the default parameters: a 10 ns clock and the 85 ns device grade.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the outputs are in the idle state. `mem_cs_n`, `mem_oe_n` and `mem_we_n` are all 1, `dq_drive` is 0, and no access is in progress.
- R2: A read keeps `mem_cs_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for exactly 9 consecutive cycles. This is the largest of the rounded read-cycle, address-access, select-access and enable-access minimums (85, 85, 85 and 40 ns).
- R3: The read byte is sampled on the last cycle of the read window. `rd_valid` is high for exactly one cycle, 9 cycles after the accepting edge, and `rd_data` then equals the byte last written to that address.
- R4: A write first spends one cycle with `mem_cs_n` at 0 and `mem_we_n` at 1. It then holds `mem_we_n` at 0 for exactly 7 cycles: the largest of the rounded minimums for pulse width (55 ns), select-to-end (70 ns), address-to-end (70 ns) and data-to-end (35 ns). After that it spends one recovery cycle with `mem_we_n` at 1 before deselecting.
- R5: `dq_drive` is 1 only while both `mem_cs_n` and `mem_we_n` are 0. `mem_oe_n` is 1 whenever `mem_we_n` is 0.
- R6: After a read, `req_ready` stays low for 3 extra cycles (25 ns release time, rounded up). The controller therefore never enables its driver while the RAM may still be driving the bus. `req_ready` returns 12 cycles after a read is accepted and 9 cycles after a write is accepted.
- R7: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low whenever `mem_cs_n` is 0.
- R8: `mem_addr` and `dq_out` do not change while `mem_cs_n` stays 0.
- R9: Writes followed by reads at random addresses, including address 0 and address 0x7FFFF, return the last byte written to each address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers an access |
| req_ready | output | 1 | Controller is idle and takes the offered access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_addr | output | 19 | RAM address lines |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| dq_out | output | 8 | Byte toward the RAM data pins |
| dq_drive | output | 1 | Enables the data-pin driver |
| dq_in | input | 8 | Byte read from the RAM data pins |

## Verification
Call the accepting edge E. The read strobe appears 9 cycles after E. Ready comes back 9 cycles after E for a write and 12 cycles after E for a read.

The driver task records the cycle count at the accepting edge and pushes the expected byte and the cycle in which it is due. The monitor samples on falling edges and compares both the data and the arrival cycle. A bench memory model counts, each cycle, how long the strobes, the address and the driven data have been held. It returns garbage if the read window is shorter than required, rejects write windows of the wrong length, and reports any bus contention within the release time.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WREC,
    ST_READ,
    ST_TURN
  } ctrl_state_t;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SET_CYC  = 1,
  parameter int PUL_CYC  = 7,
  parameter int REC_CYC  = 1,
  parameter int RD_CYC   = 9,
  parameter int TURN_CYC = 3,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  output logic             take,
  output logic             capture,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             drive,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  input  logic             t_done
);

  localparam logic [CNT_W-1:0] SET_LD  = CNT_W'(SET_CYC - 1);
  localparam logic [CNT_W-1:0] PUL_LD  = CNT_W'(PUL_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  ctrl_state_t st;

  assign take    = req_valid && req_ready;
  assign capture = (st == ST_READ) && t_done;

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (st)
      ST_IDLE: if (take) begin
        t_load = 1'b1;
        t_val  = req_write ? SET_LD : RD_LD;
      end
      ST_WSET: if (t_done) begin t_load = 1'b1; t_val = PUL_LD;  end
      ST_WPUL: if (t_done) begin t_load = 1'b1; t_val = REC_LD;  end
      ST_READ: if (t_done) begin t_load = 1'b1; t_val = TURN_LD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      req_ready <= 1'b1;
      cs_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      drive     <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (take) begin
          req_ready <= 1'b0;
          cs_n      <= 1'b0;
          if (req_write) begin
            st <= ST_WSET;
          end else begin
            oe_n <= 1'b0;
            st   <= ST_READ;
          end
        end
        ST_WSET: if (t_done) begin
          we_n  <= 1'b0;
          drive <= 1'b1;
          st    <= ST_WPUL;
        end
        ST_WPUL: if (t_done) begin
          we_n  <= 1'b1;
          drive <= 1'b0;
          st    <= ST_WREC;
        end
        ST_WREC: if (t_done) begin
          cs_n      <= 1'b1;
          req_ready <= 1'b1;
          st        <= ST_IDLE;
        end
        ST_READ: if (t_done) begin
          cs_n <= 1'b1;
          oe_n <= 1'b1;
          st   <= ST_TURN;
        end
        ST_TURN: if (t_done) begin
          req_ready <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  drive_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    drive |-> (!cs_n && !we_n));

  // R5
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);

  // R7
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !req_ready);

  // R1
  idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (cs_n && oe_n && we_n && !drive));

endmodule

// File: rtl/sram_datapath.sv
`timescale 1ns/1ps
module sram_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              capture,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (take) begin
        mem_addr <= req_addr;
        dq_out   <= req_wdata;
      end
      if (capture) begin
        rd_data <= dq_in;
      end
      rd_valid <= capture;
    end
  end

  // R3
  rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$rose(!cs_n)) |-> ($stable(mem_addr) && $stable(dq_out)));

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int RC_NS     = 85,
  parameter int AA_NS     = 85,
  parameter int CO_NS     = 85,
  parameter int OE_NS     = 40,
  parameter int WC_NS     = 85,
  parameter int WP_NS     = 55,
  parameter int CW_NS     = 70,
  parameter int AW_NS     = 70,
  parameter int DW_NS     = 35,
  parameter int AS_NS     = 0,
  parameter int WR_NS     = 0,
  parameter int RELEASE_NS = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int RD_CYC = max2(max2(ns_to_cyc(RC_NS, CLK_NS), ns_to_cyc(AA_NS, CLK_NS)),
                               max2(ns_to_cyc(CO_NS, CLK_NS), ns_to_cyc(OE_NS, CLK_NS)));
  localparam int SET_CYC = ns_to_cyc(AS_NS, CLK_NS);
  localparam int PUL_CYC = max2(max2(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(CW_NS, CLK_NS)),
                                max2(ns_to_cyc(AW_NS, CLK_NS), ns_to_cyc(DW_NS, CLK_NS)));
  localparam int REC_MIN = ns_to_cyc(WC_NS, CLK_NS) - SET_CYC - PUL_CYC;
  localparam int REC_CYC = max2(max2(REC_MIN, 1), ns_to_cyc(WR_NS, CLK_NS));
  localparam int TURN_CYC = ns_to_cyc(RELEASE_NS, CLK_NS);
  localparam int LONGEST  = max2(max2(RD_CYC, PUL_CYC), max2(max2(SET_CYC, REC_CYC), TURN_CYC));
  localparam int CNT_W    = $clog2(LONGEST + 1);

  logic             take;
  logic             capture;
  logic             t_load;
  logic             t_done;
  logic [CNT_W-1:0] t_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  sram_ctrl_fsm #(
    .SET_CYC  (SET_CYC),
    .PUL_CYC  (PUL_CYC),
    .REC_CYC  (REC_CYC),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .take      (take),
    .capture   (capture),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .drive     (dq_drive),
    .t_load    (t_load),
    .t_val     (t_val),
    .t_done    (t_done)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .capture   (capture),
    .cs_n      (mem_cs_n),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (dq_in),
    .mem_addr  (mem_addr),
    .dq_out    (dq_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // R2
  read_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  localparam int RD_W    = 9;   // R2 read window cycles
  localparam int WP_W    = 7;   // R4 write pulse cycles
  localparam int RD_DONE = 13;  // R6 ready seen, counted from the offer cycle
  localparam int WR_DONE = 10;
  localparam int REL_W   = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr  = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, dq_drive;
  logic [7:0]  dq_out;
  logic [7:0]  dq_in;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  logic [7:0] ram   [int];
  logic [7:0] shadow[int];
  int exp_q[$];

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .dq_out(dq_out), .dq_drive(dq_drive), .dq_in(dq_in)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory model state, all sampled at falling edges.
  int  rd_cnt = 0, wp_cnt = 0, rel = 0;
  bit  was_writing = 1'b0;
  logic [18:0] w_addr;
  logic [7:0]  w_data;

  always_comb begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      dq_in = (rd_cnt >= RD_W) ? (ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00) : 8'hEE;
    else
      dq_in = 8'h00;
  end

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit reading = !mem_cs_n && !mem_oe_n && mem_we_n;
      automatic bit writing = !mem_cs_n && !mem_we_n;
      if (reading) begin rd_cnt++; rel = REL_W; end
      else begin rd_cnt = 0; if (rel > 0) rel--; end
      if (dq_drive && (!mem_cs_n ? !writing : 1'b1))
        check(1'b0, "R5", "driver outside write window", dq_drive, 0);
      if (!mem_we_n && !mem_oe_n)
        check(1'b0, "R5", "oe low during write", mem_oe_n, 1);
      if (dq_drive && (reading || rel > 0))
        check(1'b0, "R6", "bus contention", rel, 0);
      if (writing) begin
        if (was_writing && (mem_addr != w_addr || dq_out != w_data))
          check(1'b0, "R8", "addr/data moved in write", int'(mem_addr), int'(w_addr));
        wp_cnt++;
        w_addr = mem_addr;
        w_data = dq_out;
      end else if (was_writing) begin
        check(wp_cnt == WP_W, "R4", "write pulse cycles", wp_cnt, WP_W);
        ram[int'(w_addr)] = w_data;
        wp_cnt = 0;
      end
      was_writing = writing;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected rd_valid", 1, 0);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic int due = exp_q.pop_front();
        check(rd_data == e[7:0], "R9", "read data", rd_data, e);
        check(cyc == due, "R3", "rd_valid cycle", cyc, due);
      end
    end
  end

  // Called at a falling edge.
  task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d);
    int n;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    n = cyc;
    if (wr) shadow[int'(a)] = d;
    else begin
      exp_q.push_back(shadow.exists(int'(a)) ? int'(shadow[int'(a)]) : 0);
      exp_q.push_back(n + 1 + RD_W);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R7", "ready low after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
    check(cyc - n == (wr ? WR_DONE : RD_DONE), "R6", "ready return latency",
          cyc - n, wr ? WR_DONE : RD_DONE);
    check(mem_cs_n && mem_oe_n && mem_we_n && !dq_drive, "R1", "idle strobes",
          {mem_cs_n, mem_oe_n, mem_we_n, dq_drive}, 4'b1110);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      check(1'b0, "WD", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes after reset",
          {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    check(!dq_drive && req_ready && !rd_valid, "R1", "driver/ready after reset",
          {dq_drive, req_ready, rd_valid}, 3'b010);

    do_req(1'b1, 19'h00000, 8'hA5);
    do_req(1'b0, 19'h00000, 8'h00);
    do_req(1'b1, 19'h7FFFF, 8'h3C);
    do_req(1'b0, 19'h7FFFF, 8'h00);
    do_req(1'b0, 19'h12345, 8'h00);           // never written: reads 0
    do_req(1'b1, 19'h00000, 8'h5A);           // overwrite, then read
    do_req(1'b0, 19'h00000, 8'h00);

    for (int i = 0; i < 40; i++) begin
      automatic logic [18:0] a = 19'($urandom);
      automatic logic [7:0]  d = 8'($urandom);
      do_req(1'b1, a, d);
      do_req(1'b0, a, 8'h00);
    end
    for (int i = 0; i < 10; i++) begin
      automatic logic [18:0] a = 19'($urandom % 4);
      do_req($urandom % 2 == 1, a, 8'($urandom));
    end

    repeat (15) @(negedge clk);
    check(exp_q.size() == 0, "R3", "reads left unanswered", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule